// File: doc/BRIEF.md
# Integration Capacitor Switch Controller

This block drives the switches of a binary-weighted integration capacitor array in a switched-capacitor accumulator for an adaptive first-order delta-sigma loop. It takes the 8-bit step magnitude produced by the adaptation stage and locates its most significant set bit. That position, the gain exponent, selects a total integration capacitance of 2^j units. A unit base capacitor is always present, and the switched capacitors C0..C(j-1) of sizes 1, 2, 4, ... units are added to it. The amplifier output gain is therefore 2^-j.

Each of the seven switched capacitors has two controls. One connects its switched port to the amplifier output, which adds the capacitor to the active array. The other ties that port to the reference node, which removes the capacitor from the array without losing its charge. The configuration is registered only on clock edges that fall in the sampling section of the modulator period, so the array never changes during accumulation. The exponent is also brought out for a digital model or for checking.

Top module: `cap_switch_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released until the first update, gain_exp_o is 0, cap_to_out_o is 0000000 and cap_to_ref_o is 1111111.
- R2: After an update, gain_exp_o equals the bit index (0 to 7) of the most significant 1 in step_mag_i. Bits below that 1 have no effect.
- R3: A step_mag_i of zero gives gain_exp_o = 0, the minimum capacitance.
- R4: After an update with exponent j, bit i of cap_to_out_o (capacitor Ci, weight 2^i units) is 1 exactly when i < j. The total capacitance, 1 + sum of the enabled weights, is then 2^j units.
- R5: For every capacitor, the output control and the reference control are complementary. Exactly one of them is 1 in every cycle.
- R6: The outputs update only on a rising clk_i edge at which samp_phase_i is 1. At an edge with samp_phase_i at 0, the outputs hold whatever step_mag_i is.
- R7: The value of step_mag_i present at an updating edge appears on the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_phase_i | input | 1 | High while the loop is in its sampling section |
| step_mag_i | input | 8 | Step magnitude from the adaptation stage |
| cap_to_out_o | output | 7 | Per capacitor: connect switched port to amplifier output |
| cap_to_ref_o | output | 7 | Per capacitor: connect switched port to reference node |
| gain_exp_o | output | 3 | Leading-one position j, gain is 2^-j |

## Verification
A wrong leading-one decode shows at the ports on the first sampling edge: gain_exp_o and the capacitor mask then disagree with the magnitude's top bit. A sweep over every one of the 256 magnitudes therefore exposes it at once. A mask that is not a prefix of enabled capacitors, or a pair of controls that are not complementary, gives a total capacitance other than 2^j, and this is visible in the same cycle. An update outside the sampling section appears one edge early as a changed mask while samp_phase_i is low. The bench detects this by changing the magnitude during accumulation and checking that the outputs hold.

// File: rtl/cap_switch_pkg.sv
package cap_switch_pkg;
  localparam int unsigned MAG_W = 8;
  localparam int unsigned EXP_W = $clog2(MAG_W);
  localparam int unsigned NCAP  = MAG_W - 1;
endpackage

// File: rtl/lead_one_enc.sv
module lead_one_enc #(
  parameter int unsigned MAG_W = 8,
  localparam int unsigned EXP_W = $clog2(MAG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  output logic [EXP_W-1:0] exp_o
);
  // zero magnitude falls through to exponent 0
  always_comb begin
    exp_o = '0;
    for (int i = 0; i < MAG_W; i++)
      if (mag_i[i]) exp_o = EXP_W'(i);
  end

  AST_LEAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_i != '0) |-> ((mag_i >> exp_o) == MAG_W'(1))); // R2
  AST_ZERO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_i == '0) |-> (exp_o == '0)); // R3
endmodule

// File: rtl/cap_mask_gen.sv
module cap_mask_gen #(
  parameter int unsigned NCAP = 7,
  parameter int unsigned EXP_W = 3
) (
  input  logic [EXP_W-1:0] exp_i,
  output logic [NCAP-1:0]  mask_o
);
  // prefix mask: C0..C(j-1) enabled, sum 2^j - 1 plus base unit
  for (genvar g = 0; g < NCAP; g++) begin : g_bit
    assign mask_o[g] = (exp_i > EXP_W'(g));
  end
endmodule

// File: rtl/cap_switch_drv.sv
module cap_switch_drv #(
  parameter int unsigned NCAP = 7,
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_i,
  input  logic [NCAP-1:0]  mask_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [NCAP-1:0]  to_out_o,
  output logic [NCAP-1:0]  to_ref_o,
  output logic [EXP_W-1:0] exp_o
);
  logic [NCAP-1:0]  mask_q;
  logic [EXP_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      exp_q  <= '0;
    end else if (samp_i) begin
      mask_q <= mask_i;
      exp_q  <= exp_i;
    end
  end

  assign to_out_o = mask_q;
  assign to_ref_o = ~mask_q;  // removed caps parked on reference, charge kept
  assign exp_o    = exp_q;

  AST_HOLD_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_i |=> ($stable(mask_q) && $stable(exp_q))); // R6
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_i |=> (exp_q == $past(exp_i))); // R7
  AST_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q & (mask_q + 1'b1)) == '0)); // R4
  AST_EXP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mask_q) == int'(exp_q))); // R4
  AST_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((to_out_o & to_ref_o) == '0) && ((to_out_o | to_ref_o) == '1))); // R5
endmodule

// File: rtl/cap_switch_ctrl.sv
module cap_switch_ctrl
  import cap_switch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_phase_i,
  input  logic [MAG_W-1:0] step_mag_i,
  output logic [NCAP-1:0]  cap_to_out_o,
  output logic [NCAP-1:0]  cap_to_ref_o,
  output logic [EXP_W-1:0] gain_exp_o
);
  logic [EXP_W-1:0] exp_d;
  logic [NCAP-1:0]  mask_d;

  lead_one_enc #(.MAG_W(MAG_W)) u_enc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mag_i (step_mag_i),
    .exp_o (exp_d)
  );

  cap_mask_gen #(.NCAP(NCAP), .EXP_W(EXP_W)) u_mask (
    .exp_i (exp_d),
    .mask_o(mask_d)
  );

  cap_switch_drv #(.NCAP(NCAP), .EXP_W(EXP_W)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .samp_i  (samp_phase_i),
    .mask_i  (mask_d),
    .exp_i   (exp_d),
    .to_out_o(cap_to_out_o),
    .to_ref_o(cap_to_ref_o),
    .exp_o   (gain_exp_o)
  );
endmodule

// File: tb/sim_cap_switch_ctrl.sv
module sim_cap_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp = 1'b0;
  logic [7:0] mag = 8'h00;
  logic [6:0] to_out, to_ref;
  logic [2:0] gexp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cap_switch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .samp_phase_i(samp), .step_mag_i(mag),
    .cap_to_out_o(to_out), .cap_to_ref_o(to_ref), .gain_exp_o(gexp)
  );

  function automatic int lead(input logic [7:0] m);
    int r = 0;
    for (int i = 0; i < 8; i++) if (m[i]) r = i;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input int j);
    int cap = 1;
    check({req, " exp"}, int'(gexp), j);
    check({req, " mask"}, int'(to_out), (1 << j) - 1);
    check({req, " R5 ref"}, int'(to_ref), int'(~to_out) & 8'h7f);
    for (int i = 0; i < 7; i++) if (to_out[i]) cap += (1 << i);
    check("R4 total cap", cap, 1 << j);
  endtask

  task automatic apply(input logic [7:0] m, input logic s);
    @(negedge clk);
    mag  = m;
    samp = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mag = 8'hff;
    samp = 1'b1;
    #7;
    check_state("R1 in reset", 0);
    @(negedge clk);
    samp = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_state("R1 after release", 0);
    // R2 R3 R4 R5 R7: every magnitude, updated on one sampling edge
    for (int v = 0; v < 256; v++) begin
      apply(8'(v), 1'b1);
      check_state(v == 0 ? "R3 zero" : "R2 R7 sweep", lead(8'(v)));
    end
    // R6: accumulation edges hold, across many magnitudes
    apply(8'h10, 1'b1);
    check_state("R6 setup", 4);
    for (int v = 0; v < 256; v += 17) begin
      apply(8'(v), 1'b0);
      check_state("R6 hold", 4);
    end
    apply(8'h81, 1'b0);
    check_state("R6 hold high", 4);
    apply(8'h81, 1'b1);
    check_state("R6 R7 resume", 7);
    apply(8'h00, 1'b0);
    check_state("R6 hold zero", 7);
    apply(8'h00, 1'b1);
    check_state("R3 R6 resume zero", 0);
    // R2: lower bits ignored
    apply(8'h5a, 1'b1);
    check_state("R2 low bits", 6);
    apply(8'h40, 1'b1);
    check_state("R2 single", 6);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule